// File: doc/BRIEF.md
# Root Port Status and Control Register

This block is the 16-bit status and control register of one downstream root port in a full/low-speed USB host controller. It sits on a simple register bus that has a write strobe, write data and an always-valid read data word. A port line-state monitor feeds it the live conditions: device present, D+ and D- levels, low-speed detect, resume signalling and an overcurrent input. A build parameter sets the overcurrent input to active-low.

Software sets and clears the enable, reset and suspend bits with writes. These bits drive request outputs toward the port logic. Hardware events latch sticky change flags. Software clears a flag by writing a 1 to it. If a new event arrives in the same cycle as the clearing write, the event wins and the flag stays set. A disconnect drops the port enable on its own.

Top module: `rport_ctl_reg`

## Requirements
- R1: After reset the enable, reset, suspend and all three change flags are 0. With all line inputs low, the read word is 0x0080.
- R2: The read word shows these live inputs in the same cycle, and writes never alter them: connect in bit 0, D+ in bit 4, D- in bit 5, resume in bit 6, low-speed in bit 8.
- R3: Bit 7 always reads 1. Bits 15:13 always read 0, whatever is written to them.
- R4: A rising or falling edge of the connect input sets the connect-change flag (bit 1). The flag is visible in the cycle after the input changes.
- R5: A write with bit 1, 3 or 11 at 1 clears that change flag. A write with the bit at 0 leaves it unchanged.
- R6: A change event in the same cycle as a clearing write for its flag leaves the flag set.
- R7: Enable (bit 2), reset (bit 9) and suspend (bit 12) take the written value. They drive port_enable_o, port_reset_o and port_suspend_o. A write to enable does not set the enable-change flag.
- R8: A falling edge of connect while the port is enabled clears enable and sets the enable-change flag (bit 3). This holds even if a write sets enable in the same cycle. A disconnect while the port is disabled leaves bit 3 alone.
- R9: Bit 10 shows the overcurrent condition. The condition is the raw input, or the raw input inverted when OC_ACTIVE_LOW is 1.
- R10: Either edge of the overcurrent condition sets the overcurrent-change flag (bit 11) in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 16 | Write data |
| rd_data_o | output | 16 | Register read value |
| connect_i | input | 1 | Device present |
| dplus_i | input | 1 | D+ line level |
| dminus_i | input | 1 | D- line level |
| lowspeed_i | input | 1 | Low-speed device detected |
| resume_i | input | 1 | Resume signalling detected |
| ovc_raw_i | input | 1 | Overcurrent input, polarity set by OC_ACTIVE_LOW |
| port_enable_o | output | 1 | Port enable request |
| port_reset_o | output | 1 | Port reset request |
| port_suspend_o | output | 1 | Port suspend request |

## Verification
The hardest cases to reach are the collisions. One is a line event landing in the same clock as the write-1 that would clear its flag. The other is a disconnect landing in the same clock as a write that turns enable on. The stimulus table reaches both. It changes connect or the overcurrent input in the same vector that carries the clearing or enabling write, so both reach the register at one edge. A second instance built with the active-low polarity is driven from the same stimulus to cover that variant.

// File: rtl/rport_pkg.sv
package rport_pkg;
  localparam int unsigned REG_W = 16;
  // bit positions decoded by software
  localparam int unsigned B_CONN     = 0;
  localparam int unsigned B_CONN_CHG = 1;
  localparam int unsigned B_EN       = 2;
  localparam int unsigned B_EN_CHG   = 3;
  localparam int unsigned B_DP       = 4;
  localparam int unsigned B_DM       = 5;
  localparam int unsigned B_RESUME   = 6;
  localparam int unsigned B_ONE      = 7;
  localparam int unsigned B_LS       = 8;
  localparam int unsigned B_RST      = 9;
  localparam int unsigned B_OC       = 10;
  localparam int unsigned B_OC_CHG   = 11;
  localparam int unsigned B_SUSP     = 12;
  localparam int unsigned N_EDGE     = 2;  // connect, overcurrent
  localparam int unsigned N_FLAG     = 3;  // connect, enable, overcurrent changes
endpackage

// File: rtl/rport_edge_det.sv
module rport_edge_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic level_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= level_i;
  end

  assign rise_o = level_i & ~prev_q;
  assign fall_o = ~level_i & prev_q;
endmodule

// File: rtl/rport_sticky_flag.sv
module rport_sticky_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;  // event beats clear
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/rport_ctrl_bits.sv
module rport_ctrl_bits
  import rport_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             disconnect_i,
  output logic             en_o,
  output logic             rst_o,
  output logic             susp_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o   <= 1'b0;
      rst_o  <= 1'b0;
      susp_o <= 1'b0;
    end else begin
      if (disconnect_i)  en_o <= 1'b0;
      else if (wr_en_i)  en_o <= wr_data_i[B_EN];
      if (wr_en_i) begin
        rst_o  <= wr_data_i[B_RST];
        susp_o <= wr_data_i[B_SUSP];
      end
    end
  end
endmodule

// File: rtl/rport_ctl_reg.sv
module rport_ctl_reg
  import rport_pkg::*;
#(
  parameter bit OC_ACTIVE_LOW = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             connect_i,
  input  logic             dplus_i,
  input  logic             dminus_i,
  input  logic             lowspeed_i,
  input  logic             resume_i,
  input  logic             ovc_raw_i,
  output logic             port_enable_o,
  output logic             port_reset_o,
  output logic             port_suspend_o
);
  logic              oc_cond;
  logic [N_EDGE-1:0] lvl, rise, fall;
  logic [N_FLAG-1:0] f_set, f_clr, f_q;

  // polarity chosen at build time
  generate
    if (OC_ACTIVE_LOW) begin : g_oc_lo
      assign oc_cond = ~ovc_raw_i;
    end else begin : g_oc_hi
      assign oc_cond = ovc_raw_i;
    end
  endgenerate

  assign lvl = {oc_cond, connect_i};

  for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
    rport_edge_det u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .level_i(lvl[e]),
      .rise_o (rise[e]),
      .fall_o (fall[e])
    );
  end

  rport_ctrl_bits u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_data_i   (wr_data_i),
    .disconnect_i(fall[0]),
    .en_o        (port_enable_o),
    .rst_o       (port_reset_o),
    .susp_o      (port_suspend_o)
  );

  // flag 0: connect change, 1: enable change, 2: overcurrent change
  assign f_set = {rise[1] | fall[1], fall[0] & port_enable_o, rise[0] | fall[0]};
  assign f_clr = {N_FLAG{wr_en_i}} &
                 {wr_data_i[B_OC_CHG], wr_data_i[B_EN_CHG], wr_data_i[B_CONN_CHG]};

  for (genvar f = 0; f < N_FLAG; f++) begin : g_flag
    rport_sticky_flag u_flag (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .set_i (f_set[f]),
      .clr_i (f_clr[f]),
      .flag_o(f_q[f])
    );
  end

  always_comb begin
    rd_data_o             = '0;
    rd_data_o[B_CONN]     = connect_i;
    rd_data_o[B_CONN_CHG] = f_q[0];
    rd_data_o[B_EN]       = port_enable_o;
    rd_data_o[B_EN_CHG]   = f_q[1];
    rd_data_o[B_DP]       = dplus_i;
    rd_data_o[B_DM]       = dminus_i;
    rd_data_o[B_RESUME]   = resume_i;
    rd_data_o[B_ONE]      = 1'b1;
    rd_data_o[B_LS]       = lowspeed_i;
    rd_data_o[B_RST]      = port_reset_o;
    rd_data_o[B_OC]       = oc_cond;
    rd_data_o[B_OC_CHG]   = f_q[2];
    rd_data_o[B_SUSP]     = port_suspend_o;
  end
endmodule

// File: rtl/rport_ctl_chk.sv
module rport_ctl_chk
  import rport_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [REG_W-1:0] wr_data_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             port_enable_o,
  input logic             port_reset_o,
  input logic             port_suspend_o
);
  logic [1:0] hist_q;  // cycles since reset, saturating at 2

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              hist_q <= '0;
    else if (hist_q != 2'd2)  hist_q <= hist_q + 2'd1;
  end

  // R4: connect edge seen on the read word sets the change flag next cycle
  a_r4_conn_edge_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_q != 2'd0 && rd_data_o[B_CONN] != $past(rd_data_o[B_CONN])) |=> rd_data_o[B_CONN_CHG]);

  // R10: overcurrent-change flag only rises after the condition moved
  a_r10_oc_flag_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_q == 2'd2 && $rose(rd_data_o[B_OC_CHG])) |->
      ($past(rd_data_o[B_OC]) != $past(rd_data_o[B_OC], 2)));

  // R8: disconnect drops enable
  a_r8_disconnect_disables: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hist_q != 2'd0 && $past(rd_data_o[B_CONN]) && !rd_data_o[B_CONN]) |=> !port_enable_o);

  // R7: reset request follows the written bit
  a_r7_reset_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (port_reset_o == $past(wr_data_i[B_RST])));

  // R7: suspend request follows the written bit
  a_r7_susp_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (port_suspend_o == $past(wr_data_i[B_SUSP])));
endmodule

bind rport_ctl_reg rport_ctl_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .wr_data_i     (wr_data_i),
  .rd_data_o     (rd_data_o),
  .port_enable_o (port_enable_o),
  .port_reset_o  (port_reset_o),
  .port_suspend_o(port_suspend_o)
);

// File: tb/rport_ctl_reg_tb_top.sv
`timescale 1ns/1ps
module rport_ctl_reg_tb_top;
  typedef struct packed {
    logic        we;
    logic [15:0] wd;
    logic        conn, dp, dm, ls, rs, oc;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 24;
  // one vector per clock; exp sampled just after the edge
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0080, 4'd1},  // R1 idle
    '{1'b0, 16'h0000, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0093, 4'd4},  // R4 connect rise
    '{1'b1, 16'h0000, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0093, 4'd5},  // R5 zero write keeps
    '{1'b1, 16'h0002, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0091, 4'd5},  // R5 clear bit1
    '{1'b1, 16'h0004, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0095, 4'd7},  // R7 enable, no bit3
    '{1'b1, 16'h0204, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0295, 4'd7},  // R7 reset
    '{1'b1, 16'h1004, 1'b1,1'b0,1'b1,1'b1,1'b1,1'b0, 16'h11E5, 4'd2},  // R2 live bits, R7 suspend
    '{1'b1, 16'hE004, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0095, 4'd3},  // R3 reserved
    '{1'b0, 16'h0000, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 16'h0C95, 4'd10}, // R10 oc rise
    '{1'b0, 16'h0000, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0895, 4'd9},  // R9 oc live off
    '{1'b1, 16'h0804, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 16'h0C95, 4'd6},  // R6 oc event beats clear
    '{1'b1, 16'h0804, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b1, 16'h0495, 4'd5},  // R5 clear bit11
    '{1'b0, 16'h0000, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0895, 4'd10}, // R10 oc fall
    '{1'b1, 16'h0804, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0095, 4'd5},  // R5
    '{1'b1, 16'h0004, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h008A, 4'd8},  // R8 disconnect beats enable write
    '{1'b1, 16'h000A, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0080, 4'd5},  // R5 clear both
    '{1'b1, 16'h0002, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0093, 4'd6},  // R6 connect beats clear
    '{1'b1, 16'h0002, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0091, 4'd5},  // R5
    '{1'b1, 16'h0004, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 16'h0095, 4'd7},  // R7
    '{1'b1, 16'h0008, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h008A, 4'd6},  // R6 enable-change beats clear
    '{1'b1, 16'h000A, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0080, 4'd5},  // R5
    '{1'b0, 16'h0000, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0083, 4'd4},  // R4
    '{1'b1, 16'h0002, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0081, 4'd5},  // R5
    '{1'b0, 16'h0000, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 16'h0082, 4'd8}   // R8 disabled disconnect, R4 fall
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [15:0] wd = '0;
  logic        conn = 1'b0, dp = 1'b0, dm = 1'b0, ls = 1'b0, rs = 1'b0, oc = 1'b0;
  logic        oc_n = 1'b1;
  logic [15:0] rd, rd_lo;
  logic        en_o, rst_o, susp_o, en_lo, rst_lo, susp_lo;
  int          checks = 0, fails = 0;

  always #2 clk = ~clk;

  rport_ctl_reg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_data_i(wd), .rd_data_o(rd),
    .connect_i(conn), .dplus_i(dp), .dminus_i(dm), .lowspeed_i(ls), .resume_i(rs),
    .ovc_raw_i(oc), .port_enable_o(en_o), .port_reset_o(rst_o), .port_suspend_o(susp_o)
  );

  rport_ctl_reg #(.OC_ACTIVE_LOW(1'b1)) dut_lo_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(we), .wr_data_i(wd), .rd_data_o(rd_lo),
    .connect_i(conn), .dplus_i(dp), .dminus_i(dm), .lowspeed_i(ls), .resume_i(rs),
    .ovc_raw_i(oc_n), .port_enable_o(en_lo), .port_reset_o(rst_lo), .port_suspend_o(susp_lo)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic step(input logic w, input logic [15:0] d);
    @(negedge clk);
    we = w; wd = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual hang expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #5;
    check("R1 reset read", rd, 16'h0080);
    check("R1 reset outputs", {13'd0, en_o, rst_o, susp_o}, 16'h0000);
    check("R9 active-low idle", rd_lo, 16'h0080);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      we = VEC[i].we; wd = VEC[i].wd;
      conn = VEC[i].conn; dp = VEC[i].dp; dm = VEC[i].dm;
      ls = VEC[i].ls; rs = VEC[i].rs; oc = VEC[i].oc;
      @(posedge clk);
      #1;
      check($sformatf("R%0d vector %0d", VEC[i].req, i), rd, VEC[i].exp);
    end

    // R7 request outputs
    step(1'b1, 16'h1204);
    check("R7 outputs set", {13'd0, en_o, rst_o, susp_o}, 16'h0007);
    step(1'b1, 16'h0000);
    check("R7 outputs clear", {13'd0, en_o, rst_o, susp_o}, 16'h0000);

    // R9 R10 active-low variant
    @(negedge clk);
    we = 1'b0; oc_n = 1'b0;
    @(posedge clk); #1;
    check("R9 active-low asserted", {14'd0, rd_lo[11:10]}, 16'h0003);
    step(1'b1, 16'h0800);
    check("R5 active-low clear", {14'd0, rd_lo[11:10]}, 16'h0001);
    @(negedge clk);
    we = 1'b0; oc_n = 1'b1;
    @(posedge clk); #1;
    check("R10 active-low release", {14'd0, rd_lo[11:10]}, 16'h0002);

    // R1 reset in the middle of activity
    @(negedge clk);
    conn = 1'b1;
    @(posedge clk); #1;
    @(negedge clk);
    conn = 1'b0; rst_n = 1'b0;
    #1;
    check("R1 async reset", rd, 16'h0080);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 16'h0000);
    check("R1 after release", rd, 16'h0080);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule